// File: doc/BRIEF.md
# I2C Expander Command Decoder

This block sits behind a byte-level I2C slave engine. The engine gives it start, repeated-start and stop events and each received byte, and asks it for a byte whenever the master reads. The decoder returns an ACK or NACK for every received byte and supplies every byte the master reads. It answers only to its own 7-bit device address. It decodes a one-byte opcode and at most one operand byte. It then drives four byte-wide output ports, samples four byte-wide input ports, moves 8-byte bursts to and from a small synchronous byte memory, keeps a global enable output, and sends write and clear strobes to a separate interrupt register block.

A read always takes two phases. A write phase carries the opcode and any operand. A repeated start with the read address follows, and then the data. Malformed transfers have fixed rules. Unknown opcodes and unaddressed traffic are NACKed. Surplus bytes are NACKed and ignored. A stop that comes before the last required byte discards the command. A memory write is held in a local buffer and reaches the memory only once all eight data bytes have arrived.

Top module: `i2cx_cmd_decoder`

## Requirements
- R1: A first byte after a start whose upper seven bits equal 0b0001001 is ACKed. Its bit 0 selects write (0) or read (1). Any other address is NACKed, and every further byte is NACKed until the next start. The decision appears on `ackValid`/`ackBit` (1 = ACK) one clock after `rxValid`.
- R2: An opcode outside the supported set is NACKed. It changes no output, and every later byte up to the next start is NACKed.
- R3: `enableOut` is 0 after reset. Opcode 0x06 sets it and opcode 0x04 clears it, both taking effect on receipt of the opcode.
- R4: Opcode 0x01, followed by a port operand 0..3 and one data byte, loads that byte into output port k. Port k sits on `gpoOut[8k+7:8k]`. All ports reset to 0x00.
- R5: A port operand above 3 is NACKed. The command is dropped, and its data byte is NACKed with no effect.
- R6: Opcode 0x05 with a port operand, then a read, returns `gpiIn[8k+7:8k]` as the first byte and 0xFF for any further byte. Every `txReq` is answered on `txValid`/`txByte` one clock later.
- R7: Opcode 0x02 takes a start address and 8 data bytes. After the eighth byte, `memWe` is high for 8 consecutive cycles. The address rises by one per cycle from the start address and wraps at 8 bits, and the data goes out in arrival order.
- R8: Opcode 0x0B with a start address, then a read, returns the memory bytes at address+0 .. address+7 (wrapping at 8 bits), then 0xFF.
- R9: While `enableOut` is 0, opcodes 0x01, 0x05, 0x02 and 0x0B are NACKed and have no effect.
- R10: Bytes beyond those a command needs are NACKed and ignored. The command still takes effect.
- R11: A stop before the last required byte discards the command: no port change and no memory write.
- R12: Opcode 0x66 plus one byte pulses `irqEnWr` with that byte on `irqWdata`. Opcode 0x61 plus one byte pulses `irqClr` the same way. Opcodes 0x6A and 0x65, then a read, return `irqEnIn` and `irqStatIn` respectively. None of these depend on enable.
- R13: A read phase with no completed read command since the last stop returns 0xFF for every byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evStart | input | 1 | Start or repeated start seen (one-cycle pulse) |
| evStop | input | 1 | Stop seen (one-cycle pulse) |
| rxValid | input | 1 | Received byte valid (one-cycle pulse) |
| rxByte | input | 8 | Received byte |
| ackValid | output | 1 | Acknowledge decision valid |
| ackBit | output | 1 | 1 = ACK, 0 = NACK |
| txReq | input | 1 | Engine requests a byte to transmit |
| txValid | output | 1 | Transmit byte valid |
| txByte | output | 8 | Byte to transmit |
| gpiIn | input | 32 | Four input ports, port k at [8k+7:8k] |
| gpoOut | output | 32 | Four output ports, port k at [8k+7:8k] |
| enableOut | output | 1 | Global enable |
| memAddr | output | 8 | Memory address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write strobe |
| memRdata | input | 8 | Memory read data, one cycle after address |
| irqEnWr | output | 1 | Interrupt-enable write strobe |
| irqClr | output | 1 | Interrupt-status clear strobe |
| irqWdata | output | 8 | Data for the interrupt strobes |
| irqEnIn | input | 8 | Current interrupt-enable register |
| irqStatIn | input | 8 | Current interrupt-status register |

## Verification
The ACK decision, the transmit byte, the interrupt strobes and every port or enable change become visible one clock after the `rxValid` or `txReq` pulse that caused them. The bench drives each pulse on a falling edge and samples at the very next falling edge. A memory write fills the eight cycles after the edge that took the eighth data byte, so the bench waits a dozen cycles before it inspects its memory model or counts write strobes. Memory reads need the address held for one cycle, so transmit requests are spaced at least three cycles apart.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam logic [7:0] OP_ENABLE    = 8'h06;
  localparam logic [7:0] OP_DISABLE   = 8'h04;
  localparam logic [7:0] OP_IRQ_EN_WR = 8'h66;
  localparam logic [7:0] OP_IRQ_EN_RD = 8'h6A;
  localparam logic [7:0] OP_IRQ_ST_RD = 8'h65;
  localparam logic [7:0] OP_IRQ_CLR   = 8'h61;
  localparam logic [7:0] OP_GPO_WR    = 8'h01;
  localparam logic [7:0] OP_GPI_RD    = 8'h05;
  localparam logic [7:0] OP_MEM_WR    = 8'h02;
  localparam logic [7:0] OP_MEM_RD    = 8'h0B;

  typedef enum logic [2:0] {TX_ONES, TX_GPI, TX_IRQEN, TX_IRQST, TX_MEM} txSrc_t;

  typedef struct packed {
    logic   setEn;
    logic   clrEn;
    logic   latchPort;
    logic   gpoWr;
    logic   latchBase;
    logic   bufWr;
    logic   startCommit;
    logic   txLoad;
    logic   rdStep;
    txSrc_t txSrc;
  } strobes_t;
endpackage

// File: rtl/i2cx_ctrl.sv
module i2cx_ctrl
  import i2cx_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int BURST_LEN  = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'h09
) (
  input  logic clk,
  input  logic rstN,
  input  logic evStart,
  input  logic evStop,
  input  logic rxValid,
  input  logic [7:0] rxByte,
  input  logic txReq,
  input  logic enableIn,
  output logic ackValid,
  output logic ackBit,
  output strobes_t stb,
  output logic [$clog2(BURST_LEN)-1:0] bufIdx,
  output logic irqEnWr,
  output logic irqClr,
  output logic [7:0] irqWdata
);
  localparam int CW = $clog2(BURST_LEN + 1);
  localparam int BW = $clog2(BURST_LEN);
  localparam logic [CW-1:0] LAST = CW'(BURST_LEN - 1);
  localparam logic [CW-1:0] BURST = CW'(BURST_LEN);
  localparam logic [7:0] PORT_LIMIT = 8'(NUM_PORTS);

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_OPER, PH_DATA, PH_DONE, PH_READ, PH_IGNORE
  } phase_t;

  phase_t phase, phaseNx;
  logic [7:0] opcode, opcodeNx;
  logic pending, pendingNx;
  logic [CW-1:0] cnt, cntNx;
  logic ack, enWrNx, clrNx;

  always_comb begin
    phaseNx = phase;
    opcodeNx = opcode;
    pendingNx = pending;
    cntNx = cnt;
    ack = 1'b0;
    enWrNx = 1'b0;
    clrNx = 1'b0;
    stb = '0;
    stb.txSrc = TX_ONES;
    if (evStop) begin
      phaseNx = PH_IDLE;
      pendingNx = 1'b0;
    end else if (evStart) begin
      phaseNx = PH_ADDR;
    end else if (rxValid) begin
      case (phase)
        PH_ADDR: begin
          if (rxByte[7:1] == SLAVE_ADDR) begin
            ack = 1'b1;
            cntNx = '0;
            if (rxByte[0]) phaseNx = PH_READ;
            else begin
              phaseNx = PH_CMD;
              pendingNx = 1'b0;
            end
          end else phaseNx = PH_IGNORE;
        end
        PH_CMD: begin
          cntNx = '0;
          opcodeNx = rxByte;
          phaseNx = PH_IGNORE;
          case (rxByte)
            OP_ENABLE:  begin ack = 1'b1; stb.setEn = 1'b1; phaseNx = PH_DONE; end
            OP_DISABLE: begin ack = 1'b1; stb.clrEn = 1'b1; phaseNx = PH_DONE; end
            OP_IRQ_EN_RD, OP_IRQ_ST_RD: begin
              ack = 1'b1; pendingNx = 1'b1; phaseNx = PH_DONE;
            end
            OP_IRQ_EN_WR, OP_IRQ_CLR: begin ack = 1'b1; phaseNx = PH_DATA; end
            OP_GPO_WR, OP_GPI_RD, OP_MEM_WR, OP_MEM_RD:
              if (enableIn) begin ack = 1'b1; phaseNx = PH_OPER; end
            default: ack = 1'b0;
          endcase
        end
        PH_OPER: begin
          if (opcode == OP_GPO_WR || opcode == OP_GPI_RD) begin
            if (rxByte < PORT_LIMIT) begin
              ack = 1'b1;
              stb.latchPort = 1'b1;
              if (opcode == OP_GPO_WR) phaseNx = PH_DATA;
              else begin phaseNx = PH_DONE; pendingNx = 1'b1; end
            end else phaseNx = PH_IGNORE;
          end else begin
            ack = 1'b1;
            stb.latchBase = 1'b1;
            if (opcode == OP_MEM_WR) phaseNx = PH_DATA;
            else begin phaseNx = PH_DONE; pendingNx = 1'b1; end
          end
        end
        PH_DATA: begin
          ack = 1'b1;
          case (opcode)
            OP_IRQ_EN_WR: begin enWrNx = 1'b1; phaseNx = PH_DONE; end
            OP_IRQ_CLR:   begin clrNx = 1'b1; phaseNx = PH_DONE; end
            OP_GPO_WR:    begin stb.gpoWr = 1'b1; phaseNx = PH_DONE; end
            default: begin
              stb.bufWr = 1'b1;
              cntNx = cnt + 1'b1;
              if (cnt == LAST) begin
                stb.startCommit = 1'b1;
                phaseNx = PH_DONE;
              end
            end
          endcase
        end
        default: ack = 1'b0;
      endcase
    end else if (txReq) begin
      stb.txLoad = 1'b1;
      if (phase == PH_READ) begin
        if (cnt != '1) cntNx = cnt + 1'b1;
        if (pending) begin
          case (opcode)
            OP_GPI_RD:    if (cnt == '0) stb.txSrc = TX_GPI;
            OP_IRQ_EN_RD: if (cnt == '0) stb.txSrc = TX_IRQEN;
            OP_IRQ_ST_RD: if (cnt == '0) stb.txSrc = TX_IRQST;
            OP_MEM_RD: if (cnt < BURST) begin
              stb.txSrc = TX_MEM;
              stb.rdStep = 1'b1;
            end
            default: stb.txSrc = TX_ONES;
          endcase
        end
      end
    end
  end

  assign bufIdx = cnt[BW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      opcode <= '0;
      pending <= 1'b0;
      cnt <= '0;
      ackValid <= 1'b0;
      ackBit <= 1'b0;
      irqEnWr <= 1'b0;
      irqClr <= 1'b0;
      irqWdata <= '0;
    end else begin
      phase <= phaseNx;
      opcode <= opcodeNx;
      pending <= pendingNx;
      cnt <= cntNx;
      ackValid <= rxValid && !evStart && !evStop;
      ackBit <= ack;
      irqEnWr <= enWrNx;
      irqClr <= clrNx;
      if (rxValid) irqWdata <= rxByte;
    end
  end

  AST_FOREIGN_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !evStart && !evStop && phase == PH_IGNORE) |=> (ackValid && !ackBit)); // R1
  AST_EXTRA_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !evStart && !evStop && phase == PH_DONE) |=> (ackValid && !ackBit)); // R10
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    evStop |=> (phase == PH_IDLE && !pending)); // R11
endmodule

// File: rtl/i2cx_dpath.sv
module i2cx_dpath
  import i2cx_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int BURST_LEN = 8,
  parameter int MEM_AW    = 8
) (
  input  logic clk,
  input  logic rstN,
  input  strobes_t stb,
  input  logic [7:0] rxByte,
  input  logic [$clog2(BURST_LEN)-1:0] bufIdx,
  input  logic [8*NUM_PORTS-1:0] gpiFlat,
  input  logic [7:0] memRdata,
  input  logic [7:0] irqEnIn,
  input  logic [7:0] irqStatIn,
  output logic enableOut,
  output logic [8*NUM_PORTS-1:0] gpoFlat,
  output logic [MEM_AW-1:0] memAddr,
  output logic [7:0] memWdata,
  output logic memWe,
  output logic txValid,
  output logic [7:0] txByte
);
  localparam int PW = $clog2(NUM_PORTS);
  localparam int BW = $clog2(BURST_LEN);
  localparam logic [BW-1:0] LAST_IDX = BW'(BURST_LEN - 1);

  logic [PW-1:0] portSel;
  logic [MEM_AW-1:0] base, rdIdx;
  logic [7:0] bufR [BURST_LEN];
  logic commitActive;
  logic [BW-1:0] commitIdx;
  logic [7:0] gpiByte;

  assign gpiByte = gpiFlat[{portSel, 3'b000} +: 8];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPort
    logic [7:0] portReg;
    always_ff @(posedge clk) begin
      if (!rstN) portReg <= '0;
      else if (stb.gpoWr && portSel == PW'(g)) portReg <= rxByte;
    end
    assign gpoFlat[8*g +: 8] = portReg;
  end

  always_ff @(posedge clk) begin
    if (stb.bufWr) bufR[bufIdx] <= rxByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableOut <= 1'b0;
      portSel <= '0;
      base <= '0;
      rdIdx <= '0;
      commitActive <= 1'b0;
      commitIdx <= '0;
      txValid <= 1'b0;
      txByte <= 8'hFF;
    end else begin
      if (stb.setEn) enableOut <= 1'b1;
      else if (stb.clrEn) enableOut <= 1'b0;
      if (stb.latchPort) portSel <= rxByte[PW-1:0];
      if (stb.latchBase) begin
        base <= rxByte[MEM_AW-1:0];
        rdIdx <= '0;
      end else if (stb.rdStep) rdIdx <= rdIdx + 1'b1;
      if (stb.startCommit) begin
        commitActive <= 1'b1;
        commitIdx <= '0;
      end else if (commitActive) begin
        commitIdx <= commitIdx + 1'b1;
        if (commitIdx == LAST_IDX) commitActive <= 1'b0;
      end
      txValid <= stb.txLoad;
      if (stb.txLoad) begin
        case (stb.txSrc)
          TX_GPI:   txByte <= gpiByte;
          TX_IRQEN: txByte <= irqEnIn;
          TX_IRQST: txByte <= irqStatIn;
          TX_MEM:   txByte <= memRdata;
          default:  txByte <= 8'hFF;
        endcase
      end
    end
  end

  assign memAddr  = base + (commitActive ? {{(MEM_AW-BW){1'b0}}, commitIdx} : rdIdx);
  assign memWdata = bufR[commitIdx];
  assign memWe    = commitActive;

  AST_WE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> enableOut); // R9
  AST_BURST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr == MEM_AW'($past(memAddr) + 1'b1))); // R7
  AST_GPO_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!enableOut && !$past(enableOut)) |-> $stable(gpoFlat)); // R9
endmodule

// File: rtl/i2cx_cmd_decoder.sv
module i2cx_cmd_decoder
  import i2cx_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int BURST_LEN = 8,
  parameter int MEM_AW    = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'h09
) (
  input  logic clk,
  input  logic rstN,
  input  logic evStart,
  input  logic evStop,
  input  logic rxValid,
  input  logic [7:0] rxByte,
  output logic ackValid,
  output logic ackBit,
  input  logic txReq,
  output logic txValid,
  output logic [7:0] txByte,
  input  logic [8*NUM_PORTS-1:0] gpiIn,
  output logic [8*NUM_PORTS-1:0] gpoOut,
  output logic enableOut,
  output logic [MEM_AW-1:0] memAddr,
  output logic [7:0] memWdata,
  output logic memWe,
  input  logic [7:0] memRdata,
  output logic irqEnWr,
  output logic irqClr,
  output logic [7:0] irqWdata,
  input  logic [7:0] irqEnIn,
  input  logic [7:0] irqStatIn
);
  strobes_t stb;
  logic [$clog2(BURST_LEN)-1:0] bufIdx;

  i2cx_ctrl #(.NUM_PORTS(NUM_PORTS), .BURST_LEN(BURST_LEN), .SLAVE_ADDR(SLAVE_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .rxValid(rxValid), .rxByte(rxByte), .txReq(txReq), .enableIn(enableOut),
    .ackValid(ackValid), .ackBit(ackBit), .stb(stb), .bufIdx(bufIdx),
    .irqEnWr(irqEnWr), .irqClr(irqClr), .irqWdata(irqWdata)
  );

  i2cx_dpath #(.NUM_PORTS(NUM_PORTS), .BURST_LEN(BURST_LEN), .MEM_AW(MEM_AW)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rxByte(rxByte), .bufIdx(bufIdx),
    .gpiFlat(gpiIn), .memRdata(memRdata), .irqEnIn(irqEnIn), .irqStatIn(irqStatIn),
    .enableOut(enableOut), .gpoFlat(gpoOut), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe), .txValid(txValid), .txByte(txByte)
  );
endmodule

// File: tb/i2cx_cmd_decoder_tb.sv
module i2cx_cmd_decoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evStart = 1'b0, evStop = 1'b0, rxValid = 1'b0, txReq = 1'b0;
  logic [7:0] rxByte = '0;
  logic ackValid, ackBit, txValid, enableOut, memWe, irqEnWr, irqClr;
  logic [7:0] txByte, memAddr, memWdata, irqWdata;
  logic [7:0] memRdata;
  logic [31:0] gpoOut;
  logic [31:0] gpiIn = 32'hD4C3B2A1;
  logic [7:0] irqEnIn = 8'h0C, irqStatIn = 8'h03;

  int checks = 0, failures = 0;
  int weCount = 0, enWrCount = 0, clrCount = 0;
  logic [7:0] lastEnWr = '0, lastClr = '0;
  logic [7:0] memArr [256];
  logic [31:0] gpoModel = '0;

  always #5 clk = ~clk;

  i2cx_cmd_decoder dut_i (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .rxValid(rxValid), .rxByte(rxByte), .ackValid(ackValid), .ackBit(ackBit),
    .txReq(txReq), .txValid(txValid), .txByte(txByte), .gpiIn(gpiIn),
    .gpoOut(gpoOut), .enableOut(enableOut), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .irqEnWr(irqEnWr), .irqClr(irqClr), .irqWdata(irqWdata),
    .irqEnIn(irqEnIn), .irqStatIn(irqStatIn)
  );

  initial for (int a = 0; a < 256; a++) memArr[a] = 8'(a ^ 8'h5A);

  always @(posedge clk) begin
    if (memWe) begin memArr[memAddr] <= memWdata; weCount <= weCount + 1; end
    memRdata <= memArr[memAddr];
    if (irqEnWr) begin enWrCount <= enWrCount + 1; lastEnWr <= irqWdata; end
    if (irqClr) begin clrCount <= clrCount + 1; lastClr <= irqWdata; end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic startEv();
    @(negedge clk) evStart = 1'b1;
    @(negedge clk) evStart = 1'b0;
  endtask

  task automatic stopEv();
    @(negedge clk) evStop = 1'b1;
    @(negedge clk) evStop = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string tag);
    @(negedge clk) begin rxValid = 1'b1; rxByte = b; end
    @(negedge clk) rxValid = 1'b0;
    check(ackValid && ackBit == expAck, tag, {30'd0, ackValid, ackBit}, {30'd0, 1'b1, expAck});
    repeat (2) @(negedge clk);
  endtask

  task automatic readByte(input logic [7:0] exp, input string tag);
    @(negedge clk) txReq = 1'b1;
    @(negedge clk) txReq = 1'b0;
    check(txValid && txByte == exp, tag, {23'd0, txValid, txByte}, {23'd0, 1'b1, exp});
    repeat (2) @(negedge clk);
  endtask

  // Vector table: port operand, data byte, expected ACK of the operand (R4, R5)
  typedef struct packed { logic [7:0] port; logic [7:0] data; logic ackOp; } gpoVec_t;
  localparam int NV = 6;
  localparam gpoVec_t VECS [NV] = '{
    '{8'd0, 8'hA5, 1'b1}, '{8'd1, 8'h3C, 1'b1}, '{8'd2, 8'h0F, 1'b1},
    '{8'd3, 8'hF0, 1'b1}, '{8'd4, 8'h77, 1'b0}, '{8'd9, 8'h66, 1'b0}
  };

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state: R3, R4
    check(enableOut == 1'b0, "R3 reset enable", {31'd0, enableOut}, 0);
    check(gpoOut == 32'h0, "R4 reset ports", gpoOut, 0);
    check(memWe == 1'b0, "R7 reset memWe", {31'd0, memWe}, 0);

    // R9: gated commands while disabled
    startEv();
    sendByte(8'h12, 1'b1, "R1 own address write");
    sendByte(8'h01, 1'b0, "R9 gpo write nacked when disabled");
    sendByte(8'h00, 1'b0, "R9 operand nacked");
    sendByte(8'h55, 1'b0, "R9 data nacked");
    stopEv();
    check(gpoOut == 32'h0, "R9 ports untouched", gpoOut, 0);
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h0B, 1'b0, "R9 mem read nacked when disabled");
    stopEv();

    // R1: foreign address
    startEv();
    sendByte(8'h20, 1'b0, "R1 foreign address nacked");
    sendByte(8'h06, 1'b0, "R1 byte after foreign address nacked");
    stopEv();
    check(enableOut == 1'b0, "R1 foreign enable ignored", {31'd0, enableOut}, 0);

    // R2: unknown opcode
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h55, 1'b0, "R2 unknown opcode nacked");
    sendByte(8'h06, 1'b0, "R2 later byte nacked");
    stopEv();
    check(enableOut == 1'b0, "R2 no effect", {31'd0, enableOut}, 0);

    // R3: enable
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h06, 1'b1, "R3 enable acked");
    check(enableOut == 1'b1, "R3 enable set", {31'd0, enableOut}, 1);
    stopEv();

    // Vector walk: R4, R5
    for (int i = 0; i < NV; i++) begin
      startEv();
      sendByte(8'h12, 1'b1, "R1 address");
      sendByte(8'h01, 1'b1, "R4 gpo opcode");
      sendByte(VECS[i].port, VECS[i].ackOp, "R5 port operand decision");
      sendByte(VECS[i].data, VECS[i].ackOp, "R4 data byte");
      stopEv();
      if (VECS[i].ackOp) gpoModel[8*VECS[i].port[1:0] +: 8] = VECS[i].data;
      check(gpoOut == gpoModel, "R4 port contents", gpoOut, gpoModel);
    end

    // R10: extra byte after gpo write
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h01, 1'b1, "R4 opcode");
    sendByte(8'h02, 1'b1, "R4 port 2");
    sendByte(8'h99, 1'b1, "R4 data");
    sendByte(8'h42, 1'b0, "R10 surplus nacked");
    stopEv();
    gpoModel[23:16] = 8'h99;
    check(gpoOut == gpoModel, "R10 command kept", gpoOut, gpoModel);

    // R11: early stop
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h01, 1'b1, "R4 opcode");
    sendByte(8'h01, 1'b1, "R4 port 1");
    stopEv();
    check(gpoOut == gpoModel, "R11 gpo discarded", gpoOut, gpoModel);
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h02, 1'b1, "R7 opcode");
    sendByte(8'h40, 1'b1, "R7 address");
    for (int k = 0; k < 5; k++) sendByte(8'(k), 1'b1, "R7 partial data");
    stopEv();
    check(weCount == 0, "R11 no memory write", weCount, 0);

    // R6: read input port 2
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h05, 1'b1, "R6 opcode");
    sendByte(8'h02, 1'b1, "R6 port");
    startEv();
    sendByte(8'h13, 1'b1, "R1 read address");
    readByte(8'hC3, "R6 input port 2");
    readByte(8'hFF, "R6 extra read");
    stopEv();

    // R12: interrupt commands
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h66, 1'b1, "R12 enable write opcode");
    sendByte(8'h0A, 1'b1, "R12 enable write data");
    stopEv();
    check(enWrCount == 1 && lastEnWr == 8'h0A, "R12 enable strobe", {enWrCount[23:0], lastEnWr}, {24'd1, 8'h0A});
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h61, 1'b1, "R12 clear opcode");
    sendByte(8'h05, 1'b1, "R12 clear data");
    stopEv();
    check(clrCount == 1 && lastClr == 8'h05, "R12 clear strobe", {clrCount[23:0], lastClr}, {24'd1, 8'h05});
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h6A, 1'b1, "R12 enable read opcode");
    startEv();
    sendByte(8'h13, 1'b1, "R1 read address");
    readByte(8'h0C, "R12 enable readback");
    stopEv();
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h65, 1'b1, "R12 status read opcode");
    startEv();
    sendByte(8'h13, 1'b1, "R1 read address");
    readByte(8'h03, "R12 status readback");
    stopEv();

    // R7: burst write with wrap, surplus byte R10
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h02, 1'b1, "R7 opcode");
    sendByte(8'hFC, 1'b1, "R7 start address");
    for (int k = 0; k < 8; k++) sendByte(8'hD0 + 8'(k), 1'b1, "R7 burst data");
    sendByte(8'hEE, 1'b0, "R10 ninth data nacked");
    stopEv();
    check(weCount == 8, "R7 eight writes", weCount, 8);
    for (int k = 0; k < 8; k++)
      check(memArr[8'(8'hFC + k)] == 8'hD0 + 8'(k), "R7 memory content", memArr[8'(8'hFC + k)], 8'hD0 + 8'(k));

    // R8: burst read with wrap
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h0B, 1'b1, "R8 opcode");
    sendByte(8'hFC, 1'b1, "R8 start address");
    startEv();
    sendByte(8'h13, 1'b1, "R1 read address");
    for (int k = 0; k < 8; k++) readByte(8'hD0 + 8'(k), "R8 burst byte");
    readByte(8'hFF, "R8 past burst");
    stopEv();

    // R13: standalone read
    startEv();
    sendByte(8'h13, 1'b1, "R1 read address");
    readByte(8'hFF, "R13 standalone read");
    readByte(8'hFF, "R13 standalone second");
    stopEv();

    // R3: disable
    startEv();
    sendByte(8'h12, 1'b1, "R1 address");
    sendByte(8'h04, 1'b1, "R3 disable acked");
    check(enableOut == 1'b0, "R3 enable cleared", {31'd0, enableOut}, 0);
    stopEv();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule